// File: doc/BRIEF.md
# Write-Data Ordering Multiplexer

This block sits between several upstream write sources and a single downstream write-data channel. An arbiter outside the block grants the address channel to one source at a time. Every accepted address handshake records the granted port number in a small first-in first-out ordering queue. Write-data beats are then taken only from the port at the head of that queue, so data bursts leave in the same order as their addresses were accepted. The head entry is retired when the last beat of its burst completes.

The queue is fall-through. While it holds no entries and an address request is being offered, data selection follows the address select directly. Data can therefore reach the slave in the same cycle as its address, which keeps a slave from deadlocking when it holds its address ready low until it sees data valid. With no entry and no address request, selection rests on port 0. Port 0 is treated as a read-only source that never writes. The block exposes `aw_allow`, and the outside arbiter must stop granting the address channel while it is low.

Both data interfaces use valid/ready. A beat transfers in a cycle where valid and ready are both high. Downstream ready is passed back only to the selected port. Every other port sees ready low and must hold its beat until it is selected. Upstream ports must keep valid, data and last stable while ready is low.

Top module: `wr_order_mux`

## Requirements
- R1: While reset is low, and after it rises with no traffic, `w_sel` is 0, `aw_allow` is 1 and the queue holds no entries.
- R2: An address handshake (`aw_valid`, `aw_ready` and `aw_allow` all high) appends `aw_sel` to the queue. Data bursts are then routed in the order the addresses were accepted.
- R3: An entry is retired only by a downstream data handshake with `dn_w_last` high. Non-last beats leave `w_sel` unchanged.
- R4: With an empty queue, an address handshake makes `w_sel` equal `aw_sel` in the same cycle. The selected port's data is forwarded in that cycle, and if that beat is last, push and retire cancel.
- R5: With an empty queue and `aw_valid` high but `aw_ready` low, `w_sel` follows `aw_sel` combinationally.
- R6: With an empty queue and `aw_valid` low, `w_sel` is 0.
- R7: With a non-empty queue, `w_sel` is the oldest entry and `aw_sel` has no effect on it.
- R8: With 4 entries (default depth), `aw_allow` is 0 and an address handshake presented anyway adds no entry. The full queue is never treated as empty.
- R9: A cycle with both a push and a retire leaves occupancy unchanged.
- R10: `dn_w_valid`, `dn_w_data` and `dn_w_last` equal the selected port's signals. `up_w_ready` is the one-hot bit of `w_sel` ANDed with `dn_w_ready`, so all other ports see 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| aw_valid | input | 1 | Downstream address request valid |
| aw_ready | input | 1 | Downstream address ready from the slave |
| aw_sel | input | IDX_W (2) | Port granted on the address channel |
| aw_allow | output | 1 | High while the queue has room; the arbiter grants only then |
| up_w_valid | input | NUM_PORTS | Per-port data valid |
| up_w_ready | output | NUM_PORTS | Per-port data ready |
| up_w_data | input | NUM_PORTS*DATA_W | Per-port data, port p at bits p*DATA_W upward |
| up_w_last | input | NUM_PORTS | Per-port last-beat flag |
| dn_w_valid | output | 1 | Downstream data valid |
| dn_w_ready | input | 1 | Downstream data ready |
| dn_w_data | output | DATA_W | Downstream data |
| dn_w_last | output | 1 | Downstream last-beat flag |
| w_sel | output | IDX_W (2) | Port currently routed to the data channel |

## Verification
The hardest situation to reach is a retire of the head entry that lands in the same cycle as a new push while the queue is near full, or a push and a last beat that cancel on an empty queue. The random phases skew address and data rates against each other so that the queue repeatedly fills and drains. Directed sequences then build the exact three-entry, push-plus-retire and full-with-blocked-handshake cases.

// File: rtl/wom_pkg.sv
package wom_pkg;
  // width needed to hold values 0..n
  function automatic int cnt_width(input int n);
    int w;
    w = 1;
    while ((1 << w) <= n) w++;
    return w;
  endfunction

  function automatic int idx_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/wom_order_queue.sv
module wom_order_queue
  import wom_pkg::*;
#(
  parameter int IDX_W = 2,
  parameter int DEPTH = 4,
  localparam int CNT_W = cnt_width(DEPTH),
  localparam int PTR_W = idx_width(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [IDX_W-1:0] push_idx,
  input  logic             pop,
  output logic [IDX_W-1:0] head_idx,
  output logic [CNT_W-1:0] count,
  output logic             full
);
  logic [IDX_W-1:0] slots [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic             at_zero, push_ok, pop_ok, wr_en, rd_en;

  assign at_zero = (count == '0);
  assign full    = (count == CNT_W'(DEPTH));
  assign push_ok = push && !full;
  // a retire needs a stored entry or one arriving now
  assign pop_ok  = pop && (!at_zero || push_ok);
  // at zero occupancy a push that is retired at once never lands in storage
  assign wr_en   = push_ok && !(at_zero && pop_ok);
  assign rd_en   = pop_ok && !at_zero;
  // fall-through head
  assign head_idx = at_zero ? push_idx : slots[rd_ptr];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= bump(wr_ptr);
      if (rd_en) rd_ptr <= bump(rd_ptr);
      if (push_ok && !pop_ok)      count <= count + CNT_W'(1);
      else if (pop_ok && !push_ok) count <= count - CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) slots[wr_ptr] <= push_idx;
  end

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(DEPTH));
  // R9
  push_pop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_ok && pop_ok) |=> $stable(count));
  // R2
  push_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full && !pop) |=> (count == $past(count) + CNT_W'(1)));
endmodule

// File: rtl/wom_sel_logic.sv
module wom_sel_logic
  import wom_pkg::*;
#(
  parameter int IDX_W = 2,
  parameter int CNT_W = 3
) (
  input  logic [CNT_W-1:0] count,
  input  logic             full,
  input  logic [IDX_W-1:0] head_idx,
  input  logic             aw_valid,
  input  logic [IDX_W-1:0] aw_sel,
  output logic [IDX_W-1:0] sel
);
  logic q_empty;
  // occupancy-based emptiness; a full queue is never empty
  assign q_empty = (count == '0) && !full;

  always_comb begin
    if (!q_empty)     sel = head_idx;
    else if (aw_valid) sel = aw_sel;
    else              sel = '0;
  end
endmodule

// File: rtl/wom_w_mux.sv
module wom_w_mux #(
  parameter int NUM_PORTS = 3,
  parameter int DATA_W    = 64,
  parameter int IDX_W     = 2
) (
  input  logic [IDX_W-1:0]            sel,
  input  logic [NUM_PORTS-1:0]        up_w_valid,
  output logic [NUM_PORTS-1:0]        up_w_ready,
  input  logic [NUM_PORTS*DATA_W-1:0] up_w_data,
  input  logic [NUM_PORTS-1:0]        up_w_last,
  output logic                        dn_w_valid,
  input  logic                        dn_w_ready,
  output logic [DATA_W-1:0]           dn_w_data,
  output logic                        dn_w_last
);
  logic [NUM_PORTS-1:0] hit;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    assign hit[p]        = (sel == IDX_W'(p));
    assign up_w_ready[p] = hit[p] && dn_w_ready;
  end

  always_comb begin
    dn_w_valid = 1'b0;
    dn_w_last  = 1'b0;
    dn_w_data  = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (hit[p]) begin
        dn_w_valid = up_w_valid[p];
        dn_w_last  = up_w_last[p];
        dn_w_data  = up_w_data[p*DATA_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/wr_order_mux.sv
module wr_order_mux
  import wom_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int DATA_W    = 64,
  parameter int DEPTH     = 4,
  localparam int IDX_W    = idx_width(NUM_PORTS)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        aw_valid,
  input  logic                        aw_ready,
  input  logic [IDX_W-1:0]            aw_sel,
  output logic                        aw_allow,
  input  logic [NUM_PORTS-1:0]        up_w_valid,
  output logic [NUM_PORTS-1:0]        up_w_ready,
  input  logic [NUM_PORTS*DATA_W-1:0] up_w_data,
  input  logic [NUM_PORTS-1:0]        up_w_last,
  output logic                        dn_w_valid,
  input  logic                        dn_w_ready,
  output logic [DATA_W-1:0]           dn_w_data,
  output logic                        dn_w_last,
  output logic [IDX_W-1:0]            w_sel
);
  localparam int CNT_W = cnt_width(DEPTH);

  logic [IDX_W-1:0] head_idx;
  logic [CNT_W-1:0] q_cnt;
  logic             q_full, aw_hs, w_hs, w_done;

  assign aw_allow = !q_full;
  assign aw_hs    = aw_valid && aw_ready;
  assign w_hs     = dn_w_valid && dn_w_ready;
  assign w_done   = w_hs && dn_w_last;

  wom_order_queue #(.IDX_W(IDX_W), .DEPTH(DEPTH)) u_queue (
    .clk(clk), .rst_n(rst_n),
    .push(aw_hs), .push_idx(aw_sel), .pop(w_done),
    .head_idx(head_idx), .count(q_cnt), .full(q_full)
  );

  wom_sel_logic #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_sel (
    .count(q_cnt), .full(q_full), .head_idx(head_idx),
    .aw_valid(aw_valid), .aw_sel(aw_sel), .sel(w_sel)
  );

  wom_w_mux #(.NUM_PORTS(NUM_PORTS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_mux (
    .sel(w_sel),
    .up_w_valid(up_w_valid), .up_w_ready(up_w_ready),
    .up_w_data(up_w_data), .up_w_last(up_w_last),
    .dn_w_valid(dn_w_valid), .dn_w_ready(dn_w_ready),
    .dn_w_data(dn_w_data), .dn_w_last(dn_w_last)
  );

  // R10
  ready_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(up_w_ready) && ((up_w_ready != '0) -> dn_w_ready));
  // R3
  beat_keeps_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_cnt != '0 && w_hs && !dn_w_last) |=> $stable(w_sel));
  // R4
  first_push_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (aw_hs && aw_allow && q_cnt == '0 && !w_done) |=> (w_sel == $past(aw_sel)));
endmodule

// File: tb/sim_wr_order_mux.sv
`timescale 1ns/1ps
module sim_wr_order_mux;
  localparam int NP = 3;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          aw_valid, aw_ready, aw_allow;
  logic [1:0]    aw_sel;
  logic [NP-1:0] up_w_valid, up_w_ready, up_w_last;
  logic [NP*DW-1:0] up_w_data;
  logic          dn_w_valid, dn_w_ready, dn_w_last;
  logic [DW-1:0] dn_w_data;
  logic [1:0]    w_sel;

  int tests = 0;
  int fails = 0;
  bit done  = 0;
  int q[$];

  always #2.5 clk = ~clk;

  wr_order_mux #(.NUM_PORTS(NP), .DATA_W(DW), .DEPTH(4)) u0 (
    .clk(clk), .rst_n(rst_n), .aw_valid(aw_valid), .aw_ready(aw_ready),
    .aw_sel(aw_sel), .aw_allow(aw_allow), .up_w_valid(up_w_valid),
    .up_w_ready(up_w_ready), .up_w_data(up_w_data), .up_w_last(up_w_last),
    .dn_w_valid(dn_w_valid), .dn_w_ready(dn_w_ready), .dn_w_data(dn_w_data),
    .dn_w_last(dn_w_last), .w_sel(w_sel)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_sel(input bit av, input int as);
    if (q.size() != 0) return q[0];
    return av ? as : 0;
  endfunction

  function automatic string sel_req(input bit av, input bit ar);
    if (q.size() != 0) return "R7";
    if (av) return ar ? "R4" : "R5";
    return "R6";
  endfunction

  // one cycle: drive at negedge, check combinational outputs, update model at posedge
  task automatic step(input bit av, input bit ar, input int as,
                      input bit [NP-1:0] wv, input bit [NP-1:0] wl, input bit dr);
    int es;
    bit push, pop;
    @(negedge clk);
    aw_valid = av; aw_ready = ar; aw_sel = 2'(as);
    up_w_valid = wv; up_w_last = wl; dn_w_ready = dr;
    for (int p = 0; p < NP; p++) up_w_data[p*DW +: DW] = $urandom;
    #1;
    es = exp_sel(av, as);
    chk(sel_req(av, ar), "w_sel", 64'(w_sel), 64'(es));
    chk("R8", "aw_allow", 64'(aw_allow), 64'(q.size() < 4));
    chk("R10", "dn_w_valid", 64'(dn_w_valid), 64'(wv[es]));
    chk("R10", "dn_w_last", 64'(dn_w_last), 64'(wl[es]));
    chk("R10", "dn_w_data", 64'(dn_w_data), 64'(up_w_data[es*DW +: DW]));
    chk("R10", "up_w_ready", 64'(up_w_ready), dr ? (64'(1) << es) : 64'(0));
    push = av && ar && (q.size() < 4);
    pop  = wv[es] && dr && wl[es] && (q.size() > 0 || push);
    @(posedge clk);
    if (push) q.push_back(as);
    if (pop) void'(q.pop_front());
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, '0, '0, 0);
  endtask

  // drain every entry with single last beats
  task automatic drain();
    while (q.size() != 0) begin
      int h = q[0];
      step(0, 0, 0, 3'(1 << h), 3'(1 << h), 1);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 0; aw_valid = 0; aw_ready = 0; aw_sel = 0;
    up_w_valid = 3'b010; up_w_last = 0; up_w_data = '0; dn_w_ready = 1;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    chk("R1", "w_sel in reset", 64'(w_sel), 0);
    chk("R1", "aw_allow in reset", 64'(aw_allow), 1);
    chk("R1", "dn_w_valid in reset", 64'(dn_w_valid), 0);
    @(negedge clk); rst_n = 1;
    q.delete();
    idle(2);

    // R4: push and last beat on empty queue cancel; W forwarded same cycle
    step(1, 1, 2, 3'b100, 3'b100, 1);
    chk("R4", "queue empty after cancel", 64'(q.size()), 0);
    idle(1);
    #1 chk("R6", "w_sel rests on 0", 64'(w_sel), 0);

    // R2 / R3: order 1,2,1 with multi-beat bursts
    step(1, 1, 1, 0, 0, 0);
    step(1, 1, 2, 0, 0, 0);
    step(1, 1, 1, 0, 0, 0);
    for (int b = 0; b < 3; b++) begin
      step(0, 0, 0, 3'b010, 0, 1);
      #1 chk("R3", "non-last beat keeps head", 64'(w_sel), 1);
    end
    step(0, 0, 0, 3'b010, 3'b010, 1);
    #1 chk("R2", "second burst from port 2", 64'(w_sel), 2);
    step(0, 0, 0, 3'b100, 3'b100, 1);
    #1 chk("R2", "third burst from port 1", 64'(w_sel), 1);
    drain();

    // R9: three entries, then push + retire, then one push makes full
    step(1, 1, 1, 0, 0, 0);
    step(1, 1, 2, 0, 0, 0);
    step(1, 1, 2, 0, 0, 0);
    step(1, 1, 1, 3'b010, 3'b010, 1);
    step(1, 1, 2, 0, 0, 0);
    #1 chk("R9", "full after push+retire then push", 64'(aw_allow), 0);
    // R8: handshake offered while full adds nothing; aw_sel ignored (R7)
    step(1, 1, 1, 0, 0, 0);
    #1 chk("R8", "full head not empty", 64'(w_sel), 2);
    drain();
    #1 chk("R8", "drained to empty", 64'(w_sel), 0);

    // random phases with varying pressure
    for (int ph = 0; ph < 6; ph++) begin
      int aw_pct = 20 + ph * 15;
      int dr_pct = 90 - ph * 12;
      for (int c = 0; c < 3000; c++) begin
        bit av = ($urandom % 100) < aw_pct;
        bit ar = ($urandom % 100) < 70;
        int as = 1 + ($urandom % 2);
        bit [NP-1:0] wv = 3'($urandom) & 3'b110;
        bit [NP-1:0] wl = 3'($urandom);
        bit dr = ($urandom % 100) < dr_pct;
        step(av, ar, as, wv, wl, dr);
      end
      drain();
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule